// File: doc/BRIEF.md
# Quadrature Exciter Duty Generator

This block turns one real, already filtered and decimated audio stream into the in-phase and quadrature drive levels of a quadrature sampling exciter. Each accepted sample enters a fifteen-stage history. The quadrature component comes from an odd-symmetric fifteen-tap Hilbert filter that runs over that history. Because the filter is antisymmetric, it needs only four multiplications.

The in-phase component is the sample held in the middle of the history. It therefore lines up in time with the group delay of the filter. Both components are divided by four and moved onto a mid-scale offset, so each fits the unsigned duty range of a PWM DAC. Both duty values are presented together with a one-cycle strobe.

Upstream conditioning, the PWM counters and any choice of sideband belong to other blocks.

Top module: `hq_iq_modulator`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the whole sample history to zero and sets both duty outputs to 125, with `out_valid` low. After reset, a zero sample yields 125 on both outputs even if nonzero samples were taken before the reset.
- R2: The history advances only on a clock edge where `in_valid` is high. The new sample becomes element 14 and every element k takes the previous value of element k+1. When `in_valid` is low, `in_sample` is ignored and both duty outputs keep their values.
- R3: The quadrature value is S >>> 12, an arithmetic shift that rounds toward minus infinity. S = (h0-h14)*315 + (h2-h12)*440 + (h4-h10)*734 + (h6-h8)*2202, where hk is history element k.
- R4: The in-phase value is history element 7.
- R5: Each duty output equals 125 + v/4, where v is the in-phase or quadrature value and the division by four truncates toward zero (for example, -6 maps to 124).
- R6: Each duty output is clamped to the range 0..250. A result below 0 reads 0 and a result above 250 reads 250.
- R7: A sample accepted at clock edge k produces `out_valid` high for exactly the one cycle after edge k+1. Both duty values update at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed two's-complement audio sample |
| out_valid | output | 1 | One-cycle strobe marking new duty values |
| i_duty | output | 8 | In-phase PWM duty, 0..250 |
| q_duty | output | 8 | Quadrature PWM duty, 0..250 |

## Verification
The hardest case to reach is a negative filter sum whose low twelve bits are not zero. Only in that case does the floor of the arithmetic shift differ from truncation. The bench produces it by walking a single impulse of 400 through all fifteen positions of the history, so each tap's coefficient appears alone at the output. At position 8 the expected quadrature duty is 71; truncation instead of flooring would give 72.

A larger impulse of 4096 drives both outputs into their clamps. A small negative sample at position 7 separates truncation toward zero from flooring in the divide-by-four.

// File: rtl/hq_pkg.sv
package hq_pkg;

   localparam int HQ_TAPS   = 15;
   localparam int HQ_PAIRS  = 4;
   localparam int HQ_COEF_W = 13;

   // Folded Hilbert coefficient for pair j, where pair j spans taps 2j and 14-2j
   function automatic int hq_coef(input int j);
      case (j)
         0:       return 315;
         1:       return 440;
         2:       return 734;
         default: return 2202;
      endcase
   endfunction

endpackage

// File: rtl/hq_delay_line.sv
module hq_delay_line #(
   parameter int W     = 16,
   parameter int DEPTH = 15
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 shift_en,
   input  logic [W-1:0]         din,
   output logic [DEPTH*W-1:0]   taps
);

   localparam int TOP_LSB = (DEPTH-1)*W;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("hq_delay_line: DEPTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         taps <= '0;
      end else if (shift_en) begin
         taps <= {din, taps[DEPTH*W-1:W]};
      end
   end

   // R2: newest element is the sample just accepted
   p_newest_r2: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> taps[TOP_LSB +: W] == $past(din));

   // R2: history frozen without a strobe
   p_frozen_r2: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(taps));

endmodule

// File: rtl/hq_hilbert_q.sv
module hq_hilbert_q
   import hq_pkg::*;
#(
   parameter int W      = 16,
   parameter int QSHIFT = 12,
   parameter int ACC_W  = W + 1 + HQ_COEF_W + 2,
   parameter int QH_W   = ACC_W - QSHIFT
) (
   input  logic [HQ_TAPS*W-1:0]   taps,
   output logic signed [QH_W-1:0] q_val
);

   generate
      if (QSHIFT < 1 || QSHIFT >= ACC_W) begin : g_bad_shift
         $error("hq_hilbert_q: QSHIFT out of range");
      end
   endgenerate

   logic signed [ACC_W-1:0] prods [HQ_PAIRS];
   logic signed [ACC_W-1:0] acc;

   genvar j;
   generate
      for (j = 0; j < HQ_PAIRS; j++) begin : g_pair
         localparam int LO = 2*j;
         localparam int HI = HQ_TAPS - 1 - 2*j;
         localparam logic signed [ACC_W-1:0] COEF = ACC_W'(hq_coef(j));
         logic signed [W:0] lo_x, hi_x, diff;
         assign lo_x = {taps[LO*W + W-1], taps[LO*W +: W]};
         assign hi_x = {taps[HI*W + W-1], taps[HI*W +: W]};
         assign diff = lo_x - hi_x;
         assign prods[j] = $signed({{(ACC_W-W-1){diff[W]}}, diff}) * COEF;
      end
   endgenerate

   always_comb begin
      acc = '0;
      for (int k = 0; k < HQ_PAIRS; k++) begin
         acc = acc + prods[k];
      end
   end

   assign q_val = acc[ACC_W-1:QSHIFT];

   logic unused_bits;
   assign unused_bits = ^{acc[QSHIFT-1:0], taps};

endmodule

// File: rtl/hq_duty_map.sv
module hq_duty_map #(
   parameter int IN_W       = 16,
   parameter int SHIFT      = 2,
   parameter int MID        = 125,
   parameter int MAX        = 250,
   parameter int OUT_W      = 8,
   parameter bit ROUND_ZERO = 1'b1
) (
   input  logic signed [IN_W-1:0] val,
   output logic [OUT_W-1:0]       duty
);

   localparam int EXT_W = IN_W + 2;
   localparam logic signed [EXT_W-1:0] RND   = EXT_W'((1 << SHIFT) - 1);
   localparam logic signed [EXT_W-1:0] ZERO  = '0;
   localparam logic signed [EXT_W-1:0] MID_X = EXT_W'(MID);
   localparam logic signed [EXT_W-1:0] MAX_X = EXT_W'(MAX);

   generate
      if (IN_W < OUT_W + 1) begin : g_bad_width
         $error("hq_duty_map: IN_W too narrow for OUT_W");
      end
      if (MID > MAX) begin : g_bad_mid
         $error("hq_duty_map: MID above MAX");
      end
   endgenerate

   logic signed [EXT_W-1:0] ext, scaled, biased;
   assign ext = {{2{val[IN_W-1]}}, val};

   generate
      if (ROUND_ZERO) begin : g_trunc_zero
         assign scaled = (ext + (ext[EXT_W-1] ? RND : ZERO)) >>> SHIFT;
      end else begin : g_floor
         assign scaled = ext >>> SHIFT;
      end
   endgenerate

   assign biased = scaled + MID_X;

   always_comb begin
      if (biased < ZERO) begin
         duty = '0;
      end else if (biased > MAX_X) begin
         duty = OUT_W'(MAX);
      end else begin
         duty = biased[OUT_W-1:0];
      end
   end

endmodule

// File: rtl/hq_iq_modulator.sv
module hq_iq_modulator
   import hq_pkg::*;
#(
   parameter int SAMPLE_W    = 16,
   parameter int DUTY_MAX    = 250,
   parameter int QSHIFT      = 12,
   parameter int SCALE_SHIFT = 2,
   parameter bit ROUND_ZERO  = 1'b1,
   parameter int DUTY_W      = $clog2(DUTY_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_sample,
   output logic                out_valid,
   output logic [DUTY_W-1:0]   i_duty,
   output logic [DUTY_W-1:0]   q_duty
);

   localparam int DUTY_MID = DUTY_MAX / 2;
   localparam int CENTRE   = (HQ_TAPS - 1) / 2;
   localparam int ACC_W    = SAMPLE_W + 1 + HQ_COEF_W + 2;
   localparam int QH_W     = ACC_W - QSHIFT;

   generate
      if (SAMPLE_W < DUTY_W + 1) begin : g_bad_sample_w
         $error("hq_iq_modulator: SAMPLE_W too small");
      end
   endgenerate

   logic [HQ_TAPS*SAMPLE_W-1:0] taps;
   logic signed [QH_W-1:0]      q_val;
   logic signed [SAMPLE_W-1:0]  i_val;
   logic [DUTY_W-1:0]           i_next, q_next;
   logic                        pend;

   hq_delay_line #(.W(SAMPLE_W), .DEPTH(HQ_TAPS)) u_line (
      .clk      (clk),
      .rst      (rst),
      .shift_en (in_valid),
      .din      (in_sample),
      .taps     (taps)
   );

   hq_hilbert_q #(.W(SAMPLE_W), .QSHIFT(QSHIFT)) u_hilb (
      .taps  (taps),
      .q_val (q_val)
   );

   assign i_val = taps[CENTRE*SAMPLE_W +: SAMPLE_W];

   hq_duty_map #(.IN_W(SAMPLE_W), .SHIFT(SCALE_SHIFT), .MID(DUTY_MID),
                 .MAX(DUTY_MAX), .OUT_W(DUTY_W), .ROUND_ZERO(ROUND_ZERO)) u_map_i (
      .val  (i_val),
      .duty (i_next)
   );

   hq_duty_map #(.IN_W(QH_W), .SHIFT(SCALE_SHIFT), .MID(DUTY_MID),
                 .MAX(DUTY_MAX), .OUT_W(DUTY_W), .ROUND_ZERO(ROUND_ZERO)) u_map_q (
      .val  (q_val),
      .duty (q_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pend      <= 1'b0;
         out_valid <= 1'b0;
         i_duty    <= DUTY_W'(DUTY_MID);
         q_duty    <= DUTY_W'(DUTY_MID);
      end else begin
         pend      <= in_valid;
         out_valid <= pend;
         if (pend) begin
            i_duty <= i_next;
            q_duty <= q_next;
         end
      end
   end

   // R1: reset puts both duties at mid-scale with no strobe
   p_reset_mid_r1: assert property (@(posedge clk)
      rst |=> (i_duty == DUTY_W'(DUTY_MID)) && (q_duty == DUTY_W'(DUTY_MID)) && !out_valid);

   // R7: accepted sample yields a strobe two edges later
   p_strobe_lat_r7: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##2 out_valid);

   // R7: every strobe traces back to an accepted sample
   p_strobe_src_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> $past(in_valid, 2));

   // R2: duties hold between strobes
   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(i_duty) && $stable(q_duty));

   // R6: duties stay inside the PWM range
   p_range_r6: assert property (@(posedge clk) disable iff (rst)
      (i_duty <= DUTY_W'(DUTY_MAX)) && (q_duty <= DUTY_W'(DUTY_MAX)));

endmodule

// File: tb/test_hq_iq_modulator.sv
module test_hq_iq_modulator;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 15;

   // {sample, expected i_duty, expected q_duty}: impulse of 400 walking the history
   localparam int VEC [NVEC][3] = '{
      '{400, 125, 118}, '{0, 125, 125}, '{0, 125, 115}, '{0, 125, 125},
      '{0, 125, 107},   '{0, 125, 125}, '{0, 125, 71},  '{0, 225, 125},
      '{0, 125, 178},   '{0, 125, 125}, '{0, 125, 142}, '{0, 125, 125},
      '{0, 125, 135},   '{0, 125, 125}, '{0, 125, 132}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        vld = 1'b0;
   logic [15:0] smp = '0;
   logic        out_valid;
   logic [7:0]  i_duty, q_duty;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hq_iq_modulator i_hq_iq_modulator (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (vld),
      .in_sample (smp),
      .out_valid (out_valid),
      .i_duty    (i_duty),
      .q_duty    (q_duty)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // drive one accepted sample; returns at the negedge where the result is visible
   task automatic send(input int s);
      @(negedge clk);
      smp = 16'(s);
      vld = 1'b1;
      @(negedge clk);
      vld = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 reset out_valid", int'(out_valid), 0);
      chk("R1 reset i_duty", int'(i_duty), 125);
      chk("R1 reset q_duty", int'(q_duty), 125);

      // R3 R4 R5 R7: impulse through every history position
      for (int n = 0; n < NVEC; n++) begin
         send(VEC[n][0]);
         chk($sformatf("R7 strobe row %0d", n), int'(out_valid), 1);
         chk($sformatf("R4 R5 i row %0d", n), int'(i_duty), VEC[n][1]);
         chk($sformatf("R3 R5 q row %0d", n), int'(q_duty), VEC[n][2]);
      end
      @(negedge clk);
      chk("R7 strobe single cycle", int'(out_valid), 0);

      // R2: a sample without strobe is ignored
      send(0);
      @(negedge clk);
      smp = 16'(9999);
      repeat (3) begin
         @(negedge clk);
         chk("R2 no strobe out_valid", int'(out_valid), 0);
      end
      chk("R2 no strobe i held", int'(i_duty), 125);
      chk("R2 no strobe q held", int'(q_duty), 125);
      for (int n = 0; n < 7; n++) send(0);
      chk("R2 ignored sample absent at centre", int'(i_duty), 125);

      // R6: clamping with a large impulse
      send(4096);
      for (int m = 1; m <= 8; m++) begin
         send(0);
         if (m == 6) chk("R6 q clamp low", int'(q_duty), 0);
         if (m == 7) chk("R6 i clamp high", int'(i_duty), 250);
         if (m == 8) chk("R6 q clamp high", int'(q_duty), 250);
      end
      for (int m = 0; m < 7; m++) send(0);

      // R5: truncation toward zero for a small negative value
      send(-6);
      for (int m = 0; m < 7; m++) send(0);
      chk("R5 negative i", int'(i_duty), 124);
      chk("R5 negative q", int'(q_duty), 125);

      // R1: reset mid-stream clears history
      send(400);
      send(0);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 mid reset i", int'(i_duty), 125);
      chk("R1 mid reset q", int'(q_duty), 125);
      send(0);
      chk("R1 history cleared q", int'(q_duty), 125);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule